// File: doc/BRIEF.md
# Endpoint-Selected FIFO Access Port

This block is the processor-facing data window of a USB device controller. Software first writes a 7-bit selection register. That register names one endpoint by number, gives the direction of transfer, and sets two enable flags. After that, a single 16-bit data register moves words to or from the named endpoint. A write pushes a word into that endpoint's transmit FIFO. A read pops a word from its receive FIFO or, while the setup flag is set, from a shared setup FIFO.

Every data access is judged legal or illegal in the cycle it arrives. An illegal access touches no FIFO. It returns zero and raises a one-cycle error pulse. On the USB side, each of the sixteen transmit and sixteen receive FIFOs, plus the setup FIFO, has a plain push or pop port with full and empty flags.

The access controller is a four-state machine:
- `ST_IDLE`: no access was taken last cycle.
- `ST_RD_GRANT`: a read was served, and the read data is on the output.
- `ST_WR_GRANT`: a write was pushed.
- `ST_DENY`: an access was refused.

From any state, the next state depends only on the request seen at the edge:
- A legal read goes to `ST_RD_GRANT`.
- A legal write goes to `ST_WR_GRANT`.
- Any other read or write goes to `ST_DENY`.
- No request goes to `ST_IDLE`.
- The USB reset forces `ST_IDLE`.

Top module: `ep_access_port`

## Requirements
- R1: A write on the selection port loads the selection register with these fields: bits 3:0 are the endpoint number (0 to 15, binary), bit 4 is the direction (0 = OUT/receive, 1 = IN/transmit), bit 5 is endpoint-select, and bit 6 is setup-select. `sel_rdata` shows the new value from the cycle after the write.
- R2: Either a low `rst_n` or a high `usb_rst` clears the selection register to zero and empties every FIFO.
- R3: A data write is granted when all of these hold: endpoint-select is 1, setup-select is 0, direction is IN, and the named transmit FIFO is not full. A granted write pushes the word into that endpoint's transmit FIFO only. The USB side pops the words in write order.
- R4: A data write while direction is OUT is denied, and no FIFO changes.
- R5: A data read is granted when all of these hold: endpoint-select is 1, setup-select is 0, direction is OUT, and the named receive FIFO is not empty. A granted read pops that FIFO's oldest word and presents it on `dat_rdata`, with `dat_ok` high, one cycle after the request.
- R6: A data read while direction is IN and setup-select is 0 is denied, and no FIFO is popped.
- R7: With both endpoint-select and setup-select at 0, every data access is denied.
- R8: With setup-select at 1, a read pops the setup FIFO whatever endpoint-select and direction hold, and a write is denied.
- R9: A read from an empty receive or setup FIFO, and a write to a full transmit FIFO, are denied and leave the FIFO unchanged.
- R10: A denied access raises `acc_err` for exactly one cycle, starting one cycle after the request, with `dat_ok` low and `dat_rdata` zero.
- R11: A read and a write requested in the same cycle are denied.
- R12: Each FIFO holds 8 words. A USB push into a full FIFO and a USB pop from an empty FIFO are ignored. The per-endpoint full and empty flags track the fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Processor reset, asynchronous, active low |
| usb_rst | input | 1 | USB reset, synchronous, active high |
| sel_wr | input | 1 | Selection register write strobe |
| sel_wdata | input | 7 | Selection value {setup, epsel, dir, ep[3:0]} |
| sel_rdata | output | 7 | Current selection register |
| dat_rd | input | 1 | Data register read request |
| dat_wr | input | 1 | Data register write request |
| dat_wdata | input | 16 | Write data |
| dat_rdata | output | 16 | Read data, zero unless a read was granted |
| dat_ok | output | 1 | Previous-cycle access granted |
| acc_err | output | 1 | Previous-cycle access denied |
| tx_pop | input | 1 | USB-side transmit FIFO pop |
| tx_pop_ep | input | 4 | Endpoint for transmit pop |
| tx_pop_data | output | 16 | Head word of the chosen transmit FIFO |
| tx_full | output | 16 | Transmit FIFO full flags |
| tx_empty | output | 16 | Transmit FIFO empty flags |
| rx_push | input | 1 | USB-side receive FIFO push |
| rx_push_ep | input | 4 | Endpoint for receive push |
| rx_push_data | input | 16 | Word pushed into the receive FIFO |
| rx_full | output | 16 | Receive FIFO full flags |
| rx_empty | output | 16 | Receive FIFO empty flags |
| su_push | input | 1 | USB-side setup FIFO push |
| su_push_data | input | 16 | Word pushed into the setup FIFO |
| su_full | output | 1 | Setup FIFO full |
| su_empty | output | 1 | Setup FIFO empty |

## Verification
Each processor access is a request held for one clock cycle. Its outcome (`dat_ok`, `acc_err` and `dat_rdata`) is registered once and is due in the cycle after the request edge. The bench therefore drives on falling edges and samples at the falling edge that follows the request's rising edge. Selection readback and USB-side flag changes also settle one edge after their strobe and are sampled the same way. `tx_pop_data` is combinational, so it is read before the pop strobe is asserted. Each denial is followed by a later legal access or a flag read, which shows that the refused access left the FIFO unchanged.

// File: rtl/epp_pkg.sv
package epp_pkg;
    localparam int EP_BITS = 4;
    localparam int NUM_EP  = 1 << EP_BITS;
    localparam int SEL_W   = EP_BITS + 3;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_GRANT = 2'd1,
        ST_WR_GRANT = 2'd2,
        ST_DENY     = 2'd3
    } acc_state_e;

    typedef struct packed {
        logic               setup_sel;
        logic               ep_sel;
        logic               dir_in;
        logic [EP_BITS-1:0] ep;
    } sel_t;
endpackage

// File: rtl/epp_fifo.sv
module epp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0]   CNT_FULL = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CNT_FULL);
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PTR_LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PTR_LAST) ? '0 : rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    AST_FULL_PUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (full && push && !pop) |=> $stable(cnt)); // R12
    AST_EMPTY_POP_HELD: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (empty && pop && !push) |=> empty); // R12
endmodule

// File: rtl/epp_select_reg.sv
module epp_select_reg
    import epp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [SEL_W-1:0] wdata,
    output sel_t             sel
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sel <= '0;
        else if (clr) sel <= '0;
        else if (wr)  sel <= sel_t'(wdata);
    end

    AST_SEL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sel == '0)); // R2
    AST_SEL_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> (sel == $past(wdata))); // R1
endmodule

// File: rtl/epp_access_fsm.sv
module epp_access_fsm
    import epp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          req_rd,
    input  logic          req_wr,
    input  sel_t          sel,
    input  logic          rx_empty_sel,
    input  logic          tx_full_sel,
    input  logic          su_empty,
    input  logic [DW-1:0] rx_head,
    input  logic [DW-1:0] su_head,
    output logic          rx_pop,
    output logic          su_pop,
    output logic          tx_push,
    output logic          dat_ok,
    output logic          acc_err,
    output logic [DW-1:0] dat_rdata
);
    acc_state_e    state, nxt;
    logic [DW-1:0] rdata_q;
    logic          one_req, rd_su, rd_rx, wr_tx;

    // legality decisions for the access arriving at this edge
    always_comb begin
        one_req = req_rd ^ req_wr;
        rd_su   = one_req && req_rd && sel.setup_sel && !su_empty;
        rd_rx   = one_req && req_rd && !sel.setup_sel && sel.ep_sel
                  && !sel.dir_in && !rx_empty_sel;
        wr_tx   = one_req && req_wr && !sel.setup_sel && sel.ep_sel
                  && sel.dir_in && !tx_full_sel;
        su_pop  = rd_su;
        rx_pop  = rd_rx;
        tx_push = wr_tx;
    end

    // next state: every state leaves on the request seen at the edge
    always_comb begin
        nxt = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_RD_GRANT, ST_WR_GRANT, ST_DENY: begin
                if (rd_su || rd_rx)        nxt = ST_RD_GRANT;
                else if (wr_tx)            nxt = ST_WR_GRANT;
                else if (req_rd || req_wr) nxt = ST_DENY;
                else                       nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= ST_IDLE;
        else if (clr) state <= ST_IDLE;
        else          state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_su) rdata_q <= su_head;
        else if (rd_rx) rdata_q <= rx_head;
        else            rdata_q <= '0;
    end

    // outputs decoded from the state
    always_comb begin
        dat_ok    = 1'b0;
        acc_err   = 1'b0;
        dat_rdata = '0;
        unique case (state)
            ST_IDLE:     ;
            ST_RD_GRANT: begin dat_ok = 1'b1; dat_rdata = rdata_q; end
            ST_WR_GRANT: dat_ok = 1'b1;
            ST_DENY:     acc_err = 1'b1;
            default:     ;
        endcase
    end

    AST_WR_OUT_DENIED: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (req_wr && !sel.dir_in) |=> acc_err); // R4
    AST_RD_IN_DENIED: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (req_rd && sel.dir_in && !sel.setup_sel) |=> acc_err); // R6
    AST_NO_SEL_DENIED: assert property (@(posedge clk) disable iff (!rst_n || clr)
        ((req_rd || req_wr) && !sel.ep_sel && !sel.setup_sel) |=> acc_err); // R7
    AST_SETUP_WR_DENIED: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (req_wr && sel.setup_sel) |=> acc_err); // R8
    AST_BOTH_DENIED: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (req_rd && req_wr) |=> acc_err); // R11
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n || clr)
        acc_err |-> (dat_rdata == '0 && !dat_ok)); // R10
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (acc_err && !$past(req_rd) && !$past(req_wr)) |-> 1'b0); // R10
endmodule

// File: rtl/ep_access_port.sv
module ep_access_port
    import epp_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               usb_rst,
    input  logic               sel_wr,
    input  logic [SEL_W-1:0]   sel_wdata,
    output logic [SEL_W-1:0]   sel_rdata,
    input  logic               dat_rd,
    input  logic               dat_wr,
    input  logic [DW-1:0]      dat_wdata,
    output logic [DW-1:0]      dat_rdata,
    output logic               dat_ok,
    output logic               acc_err,
    input  logic               tx_pop,
    input  logic [EP_BITS-1:0] tx_pop_ep,
    output logic [DW-1:0]      tx_pop_data,
    output logic [NUM_EP-1:0]  tx_full,
    output logic [NUM_EP-1:0]  tx_empty,
    input  logic               rx_push,
    input  logic [EP_BITS-1:0] rx_push_ep,
    input  logic [DW-1:0]      rx_push_data,
    output logic [NUM_EP-1:0]  rx_full,
    output logic [NUM_EP-1:0]  rx_empty,
    input  logic               su_push,
    input  logic [DW-1:0]      su_push_data,
    output logic               su_full,
    output logic               su_empty
);
    sel_t          sel;
    logic          rx_pop_c, su_pop_c, tx_push_c;
    logic [DW-1:0] tx_head [NUM_EP];
    logic [DW-1:0] rx_head [NUM_EP];
    logic [DW-1:0] su_head;

    epp_select_reg u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (usb_rst),
        .wr    (sel_wr),
        .wdata (sel_wdata),
        .sel   (sel)
    );
    assign sel_rdata = sel;

    epp_access_fsm #(.DW(DW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (usb_rst),
        .req_rd       (dat_rd),
        .req_wr       (dat_wr),
        .sel          (sel),
        .rx_empty_sel (rx_empty[sel.ep]),
        .tx_full_sel  (tx_full[sel.ep]),
        .su_empty     (su_empty),
        .rx_head      (rx_head[sel.ep]),
        .su_head      (su_head),
        .rx_pop       (rx_pop_c),
        .su_pop       (su_pop_c),
        .tx_push      (tx_push_c),
        .dat_ok       (dat_ok),
        .acc_err      (acc_err),
        .dat_rdata    (dat_rdata)
    );

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        epp_fifo #(.W(DW), .DEPTH(DEPTH)) u_tx (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (usb_rst),
            .push      (tx_push_c && (sel.ep == EP_BITS'(i))),
            .push_data (dat_wdata),
            .pop       (tx_pop && (tx_pop_ep == EP_BITS'(i))),
            .head      (tx_head[i]),
            .full      (tx_full[i]),
            .empty     (tx_empty[i])
        );
        epp_fifo #(.W(DW), .DEPTH(DEPTH)) u_rx (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (usb_rst),
            .push      (rx_push && (rx_push_ep == EP_BITS'(i))),
            .push_data (rx_push_data),
            .pop       (rx_pop_c && (sel.ep == EP_BITS'(i))),
            .head      (rx_head[i]),
            .full      (rx_full[i]),
            .empty     (rx_empty[i])
        );
    end

    epp_fifo #(.W(DW), .DEPTH(DEPTH)) u_su (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (usb_rst),
        .push      (su_push),
        .push_data (su_push_data),
        .pop       (su_pop_c),
        .head      (su_head),
        .full      (su_full),
        .empty     (su_empty)
    );

    assign tx_pop_data = tx_head[tx_pop_ep];

    AST_PUSH_ONLY_IN: assert property (@(posedge clk) disable iff (!rst_n || usb_rst)
        (dat_wr && !sel.dir_in) |=> $stable(tx_empty)); // R4
    AST_POP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n || usb_rst)
        $onehot0({rx_pop_c, su_pop_c, tx_push_c})); // R8
endmodule

// File: tb/sim_ep_access_port.sv
module sim_ep_access_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, usb_rst = 1'b0;
    logic        sel_wr = 1'b0;
    logic [6:0]  sel_wdata = '0, sel_rdata;
    logic        dat_rd = 1'b0, dat_wr = 1'b0;
    logic [15:0] dat_wdata = '0, dat_rdata;
    logic        dat_ok, acc_err;
    logic        tx_pop = 1'b0;
    logic [3:0]  tx_pop_ep = '0;
    logic [15:0] tx_pop_data;
    logic [15:0] tx_full, tx_empty, rx_full, rx_empty;
    logic        rx_push = 1'b0;
    logic [3:0]  rx_push_ep = '0;
    logic [15:0] rx_push_data = '0;
    logic        su_push = 1'b0;
    logic [15:0] su_push_data = '0;
    logic        su_full, su_empty;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ep_access_port u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sel_set(input logic setup, input logic epsel, input logic dir, input logic [3:0] ep);
        @(negedge clk); sel_wr = 1'b1; sel_wdata = {setup, epsel, dir, ep};
        @(negedge clk); sel_wr = 1'b0;
    endtask

    task automatic cpu(input logic rd, input logic wr, input logic [15:0] wd);
        @(negedge clk); dat_rd = rd; dat_wr = wr; dat_wdata = wd;
        @(negedge clk); dat_rd = 1'b0; dat_wr = 1'b0;
    endtask

    task automatic rx_in(input logic [3:0] ep, input logic [15:0] d);
        @(negedge clk); rx_push = 1'b1; rx_push_ep = ep; rx_push_data = d;
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic su_in(input logic [15:0] d);
        @(negedge clk); su_push = 1'b1; su_push_data = d;
        @(negedge clk); su_push = 1'b0;
    endtask

    task automatic tx_out(input logic [3:0] ep, input logic [15:0] exp, input string req);
        @(negedge clk); tx_pop_ep = ep; #1;
        chk(req, tx_pop_data, exp);
        tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic t_reset;
        chk("R2 sel zero", sel_rdata, 0);
        chk("R2 tx empty", tx_empty, 16'hFFFF);
        chk("R2 rx empty", rx_empty, 16'hFFFF);
        chk("R2 su empty", su_empty, 1);
        chk("R2 idle outs", {dat_ok, acc_err}, 0);
    endtask

    task automatic t_select;
        sel_set(1'b0, 1'b1, 1'b1, 4'd5);
        chk("R1 readback", sel_rdata, 7'h35);
        sel_set(1'b1, 1'b0, 1'b0, 4'd15);
        chk("R1 readback", sel_rdata, 7'h4F);
    endtask

    task automatic t_tx_write;
        sel_set(1'b0, 1'b1, 1'b1, 4'd5);
        for (int i = 0; i < 3; i++) begin
            cpu(1'b0, 1'b1, 16'hA000 + 16'(i));
            chk("R3 write ok", {dat_ok, acc_err}, 2'b10);
        end
        chk("R3 only ep5 filled", tx_empty, 16'hFFDF);
        for (int i = 0; i < 3; i++) tx_out(4'd5, 16'hA000 + 16'(i), "R3 order");
        chk("R3 drained", tx_empty, 16'hFFFF);
    endtask

    task automatic t_wr_out_denied;
        sel_set(1'b0, 1'b1, 1'b0, 4'd2);
        cpu(1'b0, 1'b1, 16'h1234);
        chk("R4 err", {dat_ok, acc_err}, 2'b01);
        chk("R10 zero data", dat_rdata, 0);
        @(negedge clk);
        chk("R10 one cycle", acc_err, 0);
        chk("R4 no fifo change", {tx_empty, rx_empty}, 32'hFFFF_FFFF);
    endtask

    task automatic t_rx_read;
        rx_in(4'd2, 16'h0B01);
        rx_in(4'd2, 16'h0B02);
        sel_set(1'b0, 1'b1, 1'b0, 4'd2);
        cpu(1'b1, 1'b0, 0);
        chk("R5 ok", {dat_ok, acc_err}, 2'b10);
        chk("R5 data1", dat_rdata, 16'h0B01);
        cpu(1'b1, 1'b0, 0);
        chk("R5 data2", dat_rdata, 16'h0B02);
        cpu(1'b1, 1'b0, 0);
        chk("R9 empty read err", {dat_ok, acc_err, dat_rdata}, 18'h10000);
    endtask

    task automatic t_rd_in_denied;
        rx_in(4'd7, 16'h7777);
        sel_set(1'b0, 1'b1, 1'b1, 4'd7);
        cpu(1'b1, 1'b0, 0);
        chk("R6 err", {dat_ok, acc_err, dat_rdata}, 18'h10000);
        chk("R6 not popped", rx_empty[7], 0);
        sel_set(1'b0, 1'b0, 1'b0, 4'd7);
        cpu(1'b1, 1'b0, 0);
        chk("R7 no select err", acc_err, 1);
        chk("R7 not popped", rx_empty[7], 0);
        cpu(1'b0, 1'b1, 16'h5);
        chk("R7 write err", acc_err, 1);
        sel_set(1'b0, 1'b1, 1'b0, 4'd7);
        cpu(1'b1, 1'b0, 0);
        chk("R6 word kept", dat_rdata, 16'h7777);
    endtask

    task automatic t_setup;
        su_in(16'h5E01);
        su_in(16'h5E02);
        sel_set(1'b1, 1'b1, 1'b1, 4'd3);
        cpu(1'b1, 1'b0, 0);
        chk("R8 setup priority", {dat_ok, dat_rdata}, 17'h15E01);
        cpu(1'b0, 1'b1, 16'h9999);
        chk("R8 setup write err", acc_err, 1);
        chk("R8 no tx push", tx_empty, 16'hFFFF);
        sel_set(1'b1, 1'b0, 1'b0, 4'd0);
        cpu(1'b1, 1'b0, 0);
        chk("R8 setup only", dat_rdata, 16'h5E02);
        cpu(1'b1, 1'b0, 0);
        chk("R9 setup empty err", acc_err, 1);
    endtask

    task automatic t_tx_full;
        sel_set(1'b0, 1'b1, 1'b1, 4'd1);
        for (int i = 0; i < 8; i++) cpu(1'b0, 1'b1, 16'hC000 + 16'(i));
        chk("R12 tx full", tx_full[1], 1);
        cpu(1'b0, 1'b1, 16'hDEAD);
        chk("R9 full write err", acc_err, 1);
        for (int i = 0; i < 8; i++) tx_out(4'd1, 16'hC000 + 16'(i), "R9 full kept order");
        @(negedge clk); tx_pop = 1'b1; tx_pop_ep = 4'd1;
        @(negedge clk); tx_pop = 1'b0;
        chk("R12 empty pop ignored", tx_empty[1], 1);
        cpu(1'b0, 1'b1, 16'h0F0F);
        tx_out(4'd1, 16'h0F0F, "R12 after empty pop");
    endtask

    task automatic t_rx_full;
        for (int i = 0; i < 9; i++) rx_in(4'd3, 16'hE000 + 16'(i));
        chk("R12 rx full", rx_full, 16'h0008);
        sel_set(1'b0, 1'b1, 1'b0, 4'd3);
        for (int i = 0; i < 8; i++) begin
            cpu(1'b1, 1'b0, 0);
            chk("R12 rx order", dat_rdata, 16'hE000 + 16'(i));
        end
        chk("R12 ninth dropped", rx_empty[3], 1);
    endtask

    task automatic t_both;
        rx_in(4'd4, 16'h4444);
        sel_set(1'b0, 1'b1, 1'b0, 4'd4);
        cpu(1'b1, 1'b1, 16'h1);
        chk("R11 both err", {dat_ok, acc_err}, 2'b01);
        chk("R11 rx kept", rx_empty[4], 0);
        chk("R11 tx kept", tx_empty, 16'hFFFF);
        cpu(1'b1, 1'b0, 0);
        chk("R11 word intact", dat_rdata, 16'h4444);
    endtask

    task automatic t_usb_rst;
        sel_set(1'b0, 1'b1, 1'b1, 4'd9);
        cpu(1'b0, 1'b1, 16'h9);
        rx_in(4'd6, 16'h6);
        su_in(16'h1);
        @(negedge clk); usb_rst = 1'b1;
        @(negedge clk); usb_rst = 1'b0;
        chk("R2 usb rst sel", sel_rdata, 0);
        chk("R2 usb rst fifos", {tx_empty, rx_empty}, 32'hFFFF_FFFF);
        chk("R2 usb rst setup", su_empty, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_select;
        t_tx_write;
        t_wr_out_denied;
        t_rx_read;
        t_rd_in_denied;
        t_setup;
        t_tx_full;
        t_rx_full;
        t_both;
        t_usb_rst;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule